// File: doc/BRIEF.md
# SRAM Byte-Select Access Timing Controller

This block turns a single request from an internal bus into one timed access on an external asynchronous SRAM that has per-byte write-enable pins. A request carries an address, write data, byte enables and a read/write flag. The block drives the address, an active-low chip select, an active-low read strobe, one active-low write-enable per byte lane, and a direction line (high for read, low for write). For reads it returns the captured data together with a one-tick completion pulse.

The block runs on a clock at twice the bus rate, `clk_2x`. One tick of this clock is a half cycle, so a base cycle is two ticks. A 16-bit configuration word sets three things. The first is the setup delay from chip select to strobe, in half-cycle steps. The second is the read and write wait counts, where a write can take its wait count from the read setting. The third is the strobe style. In mode 0 the write-enables are pulsed only inside the strobe window, and the direction line marks the whole write access. In mode 1 the write-enables cover the whole access, and the direction line is pulsed only inside the strobe window.

The state machine has five states. IDLE waits for a request. SETUP holds the address and chip select before the strobe. STROBE holds the strobe for the base cycle plus the wait cycles. HOLD keeps the address and chip select for one half cycle after the strobe. DONE releases the chip select and pulses completion. The transitions are: accept (IDLE→SETUP on a valid request), setup-expired (SETUP→STROBE), strobe-expired (STROBE→HOLD, where read data is captured), hold-done (HOLD→DONE) and retire (DONE→IDLE).

Top module: `sram_bsel_ctrl`

## Requirements
- R1: The configuration word resets to 0. Its fields are: bits [1:0] setup code SU, bits [5:2] read wait RW, bits [8:6] write wait code WW, and bit 9 strobe mode. Bits [15:10] read as 0 and writes to them are ignored.
- R2: A request is accepted at a `clk_2x` edge while `req_ready` is high. From the next tick, `mem_cs_n` is low and `mem_addr` holds the request address, unchanged until chip select rises. The strobe first asserts 2*SU+1 ticks after `mem_cs_n` falls, which is 0.5, 1.5, 2.5 or 3.5 cycles.
- R3: A read holds `mem_rd_n` low for 2*(1+RW) ticks.
- R4: A write strobe lasts 2*(1+W) ticks. W is RW when WW=0, and WW-1 otherwise, so codes 1 to 7 give 0 to 6 wait cycles.
- R5: `mem_cs_n` stays low for exactly one tick after the strobe ends. On the next tick `mem_cs_n` is high and `rsp_done` is high for exactly one tick. The total chip-select width is 2*SU+1 + strobe ticks + 1.
- R6: In mode 0 (bit 9 = 0), a write drives `mem_rdwr` low for the whole chip-select window. During the strobe window only, it drives `mem_we_n[i]` low exactly for the lanes whose `req_be[i]` is 1. A read never drives any `mem_we_n` low.
- R7: In mode 1 (bit 9 = 1), `mem_we_n[i]` is low for the whole chip-select window for the enabled lanes, on reads and on writes alike. On writes, `mem_rdwr` is low only during the strobe window, and on reads it stays high.
- R8: Read data is sampled from `mem_dq_in` at the edge where `mem_rd_n` rises. It is presented on `rsp_rdata` while `rsp_done` is high.
- R9: `req_ready` is high only in IDLE. Requests made while the block is busy are ignored. A configuration write during an access takes effect only from the next accepted request.
- R10: On writes, `mem_dq_oe` is high and `mem_dq_out` holds the write data for the whole chip-select window. On reads, `mem_dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Clock at twice the bus rate; one tick is a half cycle |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read value, with reserved bits at 0 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_be | input | DATA_W/8 | Request byte enables |
| req_ready | output | 1 | Block is idle and takes a request |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | SRAM address |
| mem_cs_n | output | 1 | SRAM chip select, active low |
| mem_rd_n | output | 1 | SRAM read strobe, active low |
| mem_we_n | output | DATA_W/8 | Per-lane write enables, active low |
| mem_rdwr | output | 1 | Direction, 1 = read, 0 = write |
| mem_dq_out | output | DATA_W | Write data to SRAM |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_in | input | DATA_W | Read data from SRAM |

## Verification
Accesses are run across all four setup codes, at the read-wait extremes 0 and 15, and with write-wait codes of 0 (inherit), 1 (no wait) and 7 (six waits). This separates the inherit path from the direct decode, and it catches off-by-one errors in each half-cycle count. Reads and writes are mixed with full, single-lane and split byte-enable patterns in both strobe modes. This shows which of the write-enable and direction strobes spans the access, and that disabled lanes stay quiet. A request made while the block is busy, and a configuration write during an access, check that neither disturbs the current access. The memory model drives valid read data only while the read strobe is low, so data captured on the wrong edge does not match.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int CFG_W = 16;
    localparam int CNT_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } sbc_state_e;

    // Field placement: [9] mode, [8:6] write wait code, [5:2] read wait, [1:0] setup
    typedef struct packed {
        logic       bsel;
        logic [2:0] wwait;
        logic [3:0] rwait;
        logic [1:0] setup;
    } sbc_cfg_t;

    localparam int CFG_USED = $bits(sbc_cfg_t);

    // Ticks in SETUP = 2*su + 1, counter loaded with ticks-1
    function automatic logic [CNT_W-1:0] setup_load(input logic [1:0] su);
        return CNT_W'({su, 1'b0});
    endfunction

    // Wait cycles actually applied for this access
    function automatic logic [3:0] eff_wait(input sbc_cfg_t c, input logic wr);
        if (wr && (c.wwait != 3'd0)) begin
            return {1'b0, c.wwait} - 4'd1;
        end
        return c.rwait;
    endfunction

    // Ticks in STROBE = 2*(1+w), counter loaded with ticks-1
    function automatic logic [CNT_W-1:0] strobe_load(input logic [3:0] w);
        return CNT_W'({w, 1'b1});
    endfunction

endpackage

// File: rtl/sbc_cfg_reg.sv
module sbc_cfg_reg
    import sbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output sbc_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);

    localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((1 << CFG_USED) - 1);

    logic [CFG_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata & USED_MASK;
        end
    end

    assign cfg   = sbc_cfg_t'(word_q[CFG_USED-1:0]);
    assign rdata = word_q;

endmodule

// File: rtl/sbc_fsm.sv
module sbc_fsm
    import sbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  sbc_cfg_t   cfg,
    output sbc_state_e st,
    output logic       ready,
    output logic       accept,
    output logic       capture,
    output logic       wr_q,
    output logic       mode_q
);

    sbc_state_e       st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] str_ld_q;
    logic             cnt_zero;

    assign ready    = (st == ST_IDLE);
    assign accept   = ready && req_valid;
    assign cnt_zero = (cnt_q == '0);
    assign capture  = (st == ST_STROBE) && cnt_zero && !wr_q;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt_q;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_nx  = ST_SETUP;
                    cnt_nx = setup_load(cfg.setup);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_nx  = ST_STROBE;
                    cnt_nx = str_ld_q;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    st_nx = ST_HOLD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_HOLD: st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt_q    <= '0;
            str_ld_q <= '0;
            wr_q     <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            st    <= st_nx;
            cnt_q <= cnt_nx;
            if (accept) begin
                str_ld_q <= strobe_load(eff_wait(cfg, req_write));
                wr_q     <= req_write;
                mode_q   <= cfg.bsel;
            end
        end
    end

endmodule

// File: rtl/sbc_strobe_gen.sv
module sbc_strobe_gen
    import sbc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  sbc_state_e       st,
    input  logic             wr_q,
    input  logic             mode_q,
    input  logic [LANES-1:0] be_q,
    output logic             cs_n,
    output logic             rd_n,
    output logic [LANES-1:0] we_n,
    output logic             rdwr,
    output logic             dq_oe,
    output logic             done
);

    logic in_access;
    logic in_strobe;
    logic lane_window;

    assign in_strobe   = (st == ST_STROBE);
    assign in_access   = (st == ST_SETUP) || in_strobe || (st == ST_HOLD);
    assign lane_window = mode_q ? in_access : (in_strobe && wr_q);

    assign cs_n  = !in_access;
    assign rd_n  = !(in_strobe && !wr_q);
    assign rdwr  = !(wr_q && (mode_q ? in_strobe : in_access));
    assign dq_oe = wr_q && in_access;
    assign done  = (st == ST_DONE);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign we_n[i] = !(be_q[i] && lane_window);
    end

endmodule

// File: rtl/sram_bsel_ctrl.sv
module sram_bsel_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic                   clk_2x,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [CFG_W-1:0]       cfg_rdata,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   req_ready,
    output logic                   rsp_done,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_cs_n,
    output logic                   mem_rd_n,
    output logic [DATA_W/8-1:0]    mem_we_n,
    output logic                   mem_rdwr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);

    localparam int LANES = DATA_W / 8;

    sbc_cfg_t         cfg;
    sbc_state_e       st;
    logic             accept;
    logic             capture;
    logic             wr_q;
    logic             mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [LANES-1:0]  be_q;

    sbc_cfg_reg u_cfg (
        .clk   (clk_2x),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    sbc_fsm u_fsm (
        .clk       (clk_2x),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg       (cfg),
        .st        (st),
        .ready     (req_ready),
        .accept    (accept),
        .capture   (capture),
        .wr_q      (wr_q),
        .mode_q    (mode_q)
    );

    sbc_strobe_gen #(.LANES(LANES)) u_strb (
        .st     (st),
        .wr_q   (wr_q),
        .mode_q (mode_q),
        .be_q   (be_q),
        .cs_n   (mem_cs_n),
        .rd_n   (mem_rd_n),
        .we_n   (mem_we_n),
        .rdwr   (mem_rdwr),
        .dq_oe  (mem_dq_oe),
        .done   (rsp_done)
    );

    always_ff @(posedge clk_2x or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (capture) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int ADDR_W = 20,
    parameter int LANES  = 4
) (
    input logic              clk_2x,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic [LANES-1:0]  mem_we_n,
    input logic              mem_rdwr,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       cfg_rdata,
    input logic              mode_q,
    input logic              wr_q
);

    p_reserved_zero_r1: assert property (@(posedge clk_2x) disable iff (!rst_n)
        cfg_rdata[15:10] == 6'd0);

    p_addr_stable_r2: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_no_strobe_at_cs_fall_r2: assert property (@(posedge clk_2x) disable iff (!rst_n)
        ($fell(mem_cs_n) && !mode_q) |-> (mem_rd_n && (&mem_we_n)));

    p_done_single_r5: assert property (@(posedge clk_2x) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_cs_high_r5: assert property (@(posedge clk_2x) disable iff (!rst_n)
        rsp_done |-> mem_cs_n);

    p_hold_before_done_r5: assert property (@(posedge clk_2x) disable iff (!rst_n)
        rsp_done |-> ($past(!mem_cs_n) && $past(mem_rd_n)));

    p_mode0_read_quiet_r6: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (!mode_q && !wr_q && !mem_cs_n) |-> (&mem_we_n));

    p_mode1_rdwr_inside_r7: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (mode_q && !mem_rdwr) |-> !mem_cs_n);

    p_ready_idle_r9: assert property (@(posedge clk_2x) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !rsp_done));

    p_accept_starts_r9: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (req_valid && req_ready) |=> !mem_cs_n);

    p_oe_write_only_r10: assert property (@(posedge clk_2x) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs_n && mem_rd_n));

endmodule

bind sram_bsel_ctrl sbc_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sbc_chk (
    .clk_2x    (clk_2x),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_we_n  (mem_we_n),
    .mem_rdwr  (mem_rdwr),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .cfg_rdata (cfg_rdata),
    .mode_q    (mode_q),
    .wr_q      (wr_q)
);

// File: tb/test_sram_bsel_ctrl.sv
`timescale 1ns/1ps
module test_sram_bsel_ctrl;

    localparam int AW = 20;
    localparam int DW = 32;
    localparam int LN = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_be = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n;
    logic          mem_rd_n;
    logic [LN-1:0] mem_we_n;
    logic          mem_rdwr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in;

    always #2.5 clk = ~clk;

    sram_bsel_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_sram_bsel_ctrl (
        .clk_2x(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_we_n(mem_we_n), .mem_rdwr(mem_rdwr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a[11:0], a} ^ 32'h5A5A_1234;
    endfunction

    // memory drives valid data only while the read strobe is low
    assign mem_dq_in = !mem_rd_n ? mem_fn(mem_addr) : 32'hDEAD_BEEF;

    typedef struct {
        bit          wr;
        bit          mode;
        bit [AW-1:0] addr;
        bit [DW-1:0] data;
        bit [LN-1:0] be;
        int          s;
        int          t;
    } exp_t;

    exp_t exp_q[$];
    int   nchk = 0;
    int   nfail = 0;
    bit   finished = 1'b0;

    int sh_su = 0, sh_rw = 0, sh_ww = 0, sh_md = 0;

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic set_cfg(input int su, input int rw, input int ww, input int md);
        @(negedge clk);
        cfg_wdata = 16'((md << 9) | (ww << 6) | (rw << 2) | su);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_su = su; sh_rw = rw; sh_ww = ww; sh_md = md;
        chk("R1", "cfg readback", cfg_rdata, 64'(cfg_wdata));
    endtask

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] be);
        exp_t e;
        int w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        w = (wr && sh_ww != 0) ? sh_ww - 1 : sh_rw;
        e.wr = wr; e.mode = sh_md[0]; e.addr = a; e.data = d; e.be = be;
        e.s = 2 * sh_su + 1;
        e.t = 2 * (1 + w);
        exp_q.push_back(e);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready || exp_q.size() != 0) @(negedge clk);
    endtask

    // ---------------- monitor / scoreboard ----------------
    exp_t cur;
    int   idx = 0, first = -1, rd_t = 0, wel_t = 0, wea_t = 0, rdwr_t = 0, oe_t = 0;
    int   bad_addr = 0, bad_data = 0, extra = 0;
    bit   strb;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n) begin
                if (idx == 0) begin
                    if (exp_q.size() == 0) begin
                        extra++;
                        cur = '{default: 0};
                    end else begin
                        cur = exp_q[0];
                    end
                end
                strb = cur.wr ? (cur.mode ? !mem_rdwr : (mem_we_n != '1)) : !mem_rd_n;
                if (strb && first < 0) first = idx;
                rd_t   += int'(!mem_rd_n);
                wel_t  += int'(mem_we_n == ~cur.be);
                wea_t  += int'(mem_we_n != '1);
                rdwr_t += int'(!mem_rdwr);
                if (mem_addr != cur.addr) bad_addr++;
                if (mem_dq_oe) begin
                    oe_t++;
                    if (mem_dq_out != cur.data) bad_data++;
                end
                idx++;
            end
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk("R9", "done without request", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk("R2", "setup ticks", first, cur.s);
                    chk("R2", "address held", bad_addr, 0);
                    chk("R5", "cs width", idx, cur.s + cur.t + 1);
                    if (!cur.wr) begin
                        chk("R3", "read strobe ticks", rd_t, cur.t);
                        chk("R8", "read data", rsp_rdata, mem_fn(cur.addr));
                        chk("R10", "oe on read", oe_t, 0);
                        if (!cur.mode) chk("R6", "we on mode0 read", wea_t, 0);
                        else begin
                            chk("R7", "we lanes mode1 read", wel_t, idx);
                            chk("R7", "rdwr on mode1 read", rdwr_t, 0);
                        end
                    end else begin
                        chk("R10", "oe ticks", oe_t, idx);
                        chk("R10", "write data", bad_data, 0);
                        chk("R4", "no read strobe on write", rd_t, 0);
                        if (!cur.mode) begin
                            chk("R4", "we strobe ticks", wea_t, cur.t);
                            chk("R6", "we lanes mode0", wel_t, cur.t);
                            chk("R6", "rdwr whole access", rdwr_t, idx);
                        end else begin
                            chk("R4", "rdwr strobe ticks", rdwr_t, cur.t);
                            chk("R7", "we lanes mode1 write", wel_t, idx);
                        end
                    end
                end
                idx = 0; first = -1; rd_t = 0; wel_t = 0; wea_t = 0;
                rdwr_t = 0; oe_t = 0; bad_addr = 0; bad_data = 0;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R5, R9)
        chk("R1", "cfg reset", cfg_rdata, 0);
        chk("R5", "cs after reset", mem_cs_n, 1);
        chk("R5", "done after reset", rsp_done, 0);
        chk("R9", "ready after reset", req_ready, 1);

        // reserved bits ignored (R1)
        @(negedge clk);
        cfg_wdata = 16'hFFFF; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R1", "reserved bits masked", cfg_rdata, 16'h03FF);

        set_cfg(0, 0, 0, 0);
        issue(1'b0, 20'h00010, '0, 4'hF);
        issue(1'b1, 20'h00020, 32'h1122_3344, 4'hF);

        set_cfg(3, 5, 0, 0);
        issue(1'b1, 20'h0ABCD, 32'hCAFE_F00D, 4'b0101);
        issue(1'b0, 20'h0ABCE, '0, 4'hF);

        set_cfg(1, 2, 1, 0);
        issue(1'b1, 20'h12345, 32'h0BAD_0BAD, 4'b1000);

        set_cfg(2, 0, 7, 0);
        issue(1'b1, 20'h54321, 32'hA5A5_5A5A, 4'b0011);

        set_cfg(1, 3, 3, 1);
        issue(1'b0, 20'h33333, '0, 4'b0011);
        issue(1'b1, 20'h44444, 32'h7777_8888, 4'b1100);

        set_cfg(0, 15, 0, 1);
        issue(1'b1, 20'hFFFF0, 32'h0123_4567, 4'hF);
        wait_idle();

        // busy request ignored (R9)
        set_cfg(2, 1, 0, 0);
        issue(1'b0, 20'h00777, '0, 4'hF);
        req_addr = 20'hFFFFF; req_write = 1'b1; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R9", "busy request accepted", extra, 0);

        // config change mid-access applies to the next one (R9)
        issue(1'b0, 20'h01234, '0, 4'hF);
        set_cfg(3, 4, 2, 1);
        wait_idle();
        issue(1'b1, 20'h04321, 32'hFEED_BEEF, 4'b0110);
        wait_idle();

        repeat (4) @(negedge clk);
        chk("R9", "pending expected items", exp_q.size(), 0);
        chk("R9", "unexpected accesses", extra, 0);
        summary();
    end

endmodule